// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the host-facing register file of a simple raster display controller. A host reaches it through a single-word 32-bit read/write request with a 12-bit byte offset. The bank holds a control word, a status word, horizontal and vertical timing words, a packed pair of line and frame lengths, and two frame buffer base addresses. It also holds two independent 256-entry colour lookup tables in the upper half of the offset window. Every stored field is driven out as a plain signal for the timing, fetch and interrupt logic, which live elsewhere.

Each accepted request completes after a fixed pipeline delay with a one-cycle acknowledge. The acknowledge carries the read data and an error flag for offsets that decode to nothing. The length register uses a biased encoding: each 16-bit half is stored with two added and is read back with two removed. The display side reads colour entries through its own combinational port. A bank-select input on that port picks which of the two tables feeds the pixels.

Top module: `dispctl_regbank`

## Requirements
- R1: After reset, every register, both lengths, both base addresses and all 512 colour entries are zero. Reading the length register (offset 0x10) then returns 0xFFFEFFFE, and all exported fields are zero.
- R2: The word registers at offsets 0x00 (control), 0x04 (status), 0x08 (horizontal timing), 0x0C (vertical timing), 0x14 (base A) and 0x18 (base B) store all 32 written bits and return them on a read.
- R3: A write to offset 0x10 sets `line_len` to bits 31:16 plus 2 and `frame_len` to bits 15:0 plus 2, both modulo 2^16. A read returns (`line_len` − 2) in bits 31:16 and (`frame_len` − 2) in bits 15:0.
- R4: The outputs follow the stored control word: `video_en` is bit 0, `color_depth` is bits 9:8 and `pseudo_color` is bit 10. The timing and base address outputs equal their stored words. These outputs change only on the cycle in which the acknowledge is high.
- R5: Offsets 0x800 to 0xBFF address table A and offsets 0xC00 to 0xFFF address table B. The entry index is offset bits 9:2, so the low two bits are ignored. A write keeps data bits 23:0, a read returns them with bits 31:24 zero, and the two tables never alias.
- R6: `disp_color` is the entry `disp_index` of table B when `disp_bank_sel` is 1 and of table A when it is 0, and it reflects completed writes.
- R7: A request to any other offset (including unaligned register offsets such as 0x05, and 0x01C to 0x7FF) acknowledges with `rsp_err` high for that one cycle and `rsp_rdata` zero. A write to such an offset changes no register or table entry.
- R8: A request is accepted on a rising edge where `req_valid` is high and nothing is in flight. `rsp_ack` is then high for exactly one cycle, beginning with the third rising edge counted from the accepting one. `req_valid` during the two following edges is ignored, and `rsp_rdata` is zero whenever `rsp_ack` is low.
- R9: Requests to mapped offsets acknowledge with `rsp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset into the register window |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Unmapped offset, valid with `rsp_ack` |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |
| video_en | output | 1 | Control bit 0 |
| color_depth | output | 2 | Control bits 9:8 |
| pseudo_color | output | 1 | Control bit 10, palette mode |
| timing_h | output | 32 | Horizontal timing word |
| timing_v | output | 32 | Vertical timing word |
| line_len | output | 16 | Stored horizontal length (field + 2) |
| frame_len | output | 16 | Stored vertical length (field + 2) |
| fb_base_a | output | 32 | Frame buffer base A |
| fb_base_b | output | 32 | Frame buffer base B |
| disp_bank_sel | input | 1 | Colour table used for display |
| disp_index | input | 8 | Colour entry index for display |
| disp_color | output | 24 | Selected colour entry |

## Verification
The bench builds the bank with its default parameters: 32-bit data, 256 entries per table, 24-bit entries, 16-bit lengths and a bias of two. With these values the whole 12-bit window can be reached. The bench uses the last entry of each table (0xBFC and 0xFFC), the first entry of table B right at the boundary, and an unaligned palette alias. The length bias wraps at the 16-bit edge, which the reset-value readback and an all-ones write exercise.

// File: rtl/dispctl_pkg.sv
`timescale 1ns/1ps
package dispctl_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_HTIM  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_VTIM  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_LEN   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_BASEA = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_BASEB = 12'h018;

    // control word field positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_DEPTH_LO  = 8;
    localparam int CTL_PSEUDO_BIT = 10;

    typedef enum logic [3:0] {
        RG_CTRL,
        RG_STAT,
        RG_HTIM,
        RG_VTIM,
        RG_LEN,
        RG_BASEA,
        RG_BASEB,
        RG_PAL,
        RG_NONE
    } region_e;

endpackage

// File: rtl/dispctl_decode.sv
`timescale 1ns/1ps
module dispctl_decode
    import dispctl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [ADDR_W-1:0] offset,
    output region_e           region,
    output logic              pal_bank,
    output logic [IDX_W-1:0]  pal_index
);

    always_comb begin
        // upper half of the window is colour tables, next bit picks the table
        pal_bank  = offset[ADDR_W-2];
        pal_index = offset[IDX_W+1:2];
        if (offset[ADDR_W-1]) begin
            region = RG_PAL;
        end else begin
            case (offset)
                OFS_CTRL:  region = RG_CTRL;
                OFS_STAT:  region = RG_STAT;
                OFS_HTIM:  region = RG_HTIM;
                OFS_VTIM:  region = RG_VTIM;
                OFS_LEN:   region = RG_LEN;
                OFS_BASEA: region = RG_BASEA;
                OFS_BASEB: region = RG_BASEB;
                default:   region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dispctl_palette.sv
`timescale 1ns/1ps
module dispctl_palette #(
    parameter int ENTRIES = 256,
    parameter int PAL_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PAL_W-1:0] wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PAL_W-1:0] rd_data,
    input  logic             disp_bank,
    input  logic [IDX_W-1:0] disp_idx,
    output logic [PAL_W-1:0] disp_data
);

    localparam int NBANK = 2;

    logic [NBANK-1:0][PAL_W-1:0] rd_word;
    logic [NBANK-1:0][PAL_W-1:0] disp_word;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [PAL_W-1:0] mem_d [ENTRIES];
        logic [PAL_W-1:0] mem_q [ENTRIES];

        always_comb begin
            mem_d = mem_q;
            if (wr_en && (wr_bank == 1'(b))) begin
                mem_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q <= '{default: '0};
            end else begin
                mem_q <= mem_d;
            end
        end

        assign rd_word[b]   = mem_q[rd_idx];
        assign disp_word[b] = mem_q[disp_idx];
    end

    assign rd_data   = rd_word[rd_bank];
    assign disp_data = disp_word[disp_bank];

endmodule

// File: rtl/dispctl_regbank.sv
`timescale 1ns/1ps
module dispctl_regbank
    import dispctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PAL_ENTRIES = 256,
    parameter int PAL_W       = 24,
    parameter int LEN_W       = 16,
    parameter int LEN_BIAS    = 2,
    localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              video_en,
    output logic [1:0]        color_depth,
    output logic              pseudo_color,
    output logic [DATA_W-1:0] timing_h,
    output logic [DATA_W-1:0] timing_v,
    output logic [LEN_W-1:0]  line_len,
    output logic [LEN_W-1:0]  frame_len,
    output logic [DATA_W-1:0] fb_base_a,
    output logic [DATA_W-1:0] fb_base_b,
    input  logic              disp_bank_sel,
    input  logic [IDX_W-1:0]  disp_index,
    output logic [PAL_W-1:0]  disp_color
);

    localparam logic [LEN_W-1:0] BIAS = LEN_W'(LEN_BIAS);

    typedef struct packed {
        logic              s1_v;
        logic              s1_wr;
        logic [ADDR_W-1:0] s1_addr;
        logic [DATA_W-1:0] s1_data;
        logic              s2_v;
        logic              s2_wr;
        logic [ADDR_W-1:0] s2_addr;
        logic [DATA_W-1:0] s2_data;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] htim;
        logic [DATA_W-1:0] vtim;
        logic [LEN_W-1:0]  hlen;
        logic [LEN_W-1:0]  vlen;
        logic [DATA_W-1:0] base_a;
        logic [DATA_W-1:0] base_b;
    } state_t;

    state_t st_d, st_q;

    region_e          region;
    logic             pal_bank;
    logic [IDX_W-1:0] pal_index;
    logic             pal_we;
    logic [PAL_W-1:0] pal_rd;

    dispctl_decode #(.IDX_W(IDX_W)) u_decode (
        .offset   (st_q.s2_addr),
        .region   (region),
        .pal_bank (pal_bank),
        .pal_index(pal_index)
    );

    dispctl_palette #(.ENTRIES(PAL_ENTRIES), .PAL_W(PAL_W)) u_palette (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pal_we),
        .wr_bank  (pal_bank),
        .wr_idx   (pal_index),
        .wr_data  (st_q.s2_data[PAL_W-1:0]),
        .rd_bank  (pal_bank),
        .rd_idx   (pal_index),
        .rd_data  (pal_rd),
        .disp_bank(disp_bank_sel),
        .disp_idx (disp_index),
        .disp_data(disp_color)
    );

    always_comb begin
        st_d       = st_q;
        pal_we     = 1'b0;
        st_d.ack   = 1'b0;
        st_d.err   = 1'b0;
        st_d.rdata = '0;

        // stage 2 follows stage 1 unconditionally
        st_d.s2_v    = st_q.s1_v;
        st_d.s2_wr   = st_q.s1_wr;
        st_d.s2_addr = st_q.s1_addr;
        st_d.s2_data = st_q.s1_data;

        // accept only when nothing is in flight
        st_d.s1_v = req_valid && !st_q.s1_v && !st_q.s2_v;
        if (st_d.s1_v) begin
            st_d.s1_wr   = req_write;
            st_d.s1_addr = req_addr;
            st_d.s1_data = req_wdata;
        end

        if (st_q.s2_v) begin
            st_d.ack = 1'b1;
            case (region)
                RG_CTRL:  if (st_q.s2_wr) st_d.ctrl   = st_q.s2_data; else st_d.rdata = st_q.ctrl;
                RG_STAT:  if (st_q.s2_wr) st_d.stat   = st_q.s2_data; else st_d.rdata = st_q.stat;
                RG_HTIM:  if (st_q.s2_wr) st_d.htim   = st_q.s2_data; else st_d.rdata = st_q.htim;
                RG_VTIM:  if (st_q.s2_wr) st_d.vtim   = st_q.s2_data; else st_d.rdata = st_q.vtim;
                RG_BASEA: if (st_q.s2_wr) st_d.base_a = st_q.s2_data; else st_d.rdata = st_q.base_a;
                RG_BASEB: if (st_q.s2_wr) st_d.base_b = st_q.s2_data; else st_d.rdata = st_q.base_b;
                RG_LEN: begin
                    if (st_q.s2_wr) begin
                        st_d.hlen = st_q.s2_data[2*LEN_W-1:LEN_W] + BIAS;
                        st_d.vlen = st_q.s2_data[LEN_W-1:0] + BIAS;
                    end else begin
                        st_d.rdata[2*LEN_W-1:LEN_W] = st_q.hlen - BIAS;
                        st_d.rdata[LEN_W-1:0]       = st_q.vlen - BIAS;
                    end
                end
                RG_PAL: begin
                    if (st_q.s2_wr) pal_we = 1'b1;
                    else            st_d.rdata = DATA_W'(pal_rd);
                end
                default: st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_ack      = st_q.ack;
    assign rsp_err      = st_q.err;
    assign rsp_rdata    = st_q.rdata;
    assign video_en     = st_q.ctrl[CTL_EN_BIT];
    assign color_depth  = st_q.ctrl[CTL_DEPTH_LO+1:CTL_DEPTH_LO];
    assign pseudo_color = st_q.ctrl[CTL_PSEUDO_BIT];
    assign timing_h     = st_q.htim;
    assign timing_v     = st_q.vtim;
    assign line_len     = st_q.hlen;
    assign frame_len    = st_q.vlen;
    assign fb_base_a    = st_q.base_a;
    assign fb_base_b    = st_q.base_b;

endmodule

// File: rtl/dispctl_regbank_chk.sv
`timescale 1ns/1ps
module dispctl_regbank_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_ack,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              video_en
);

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack);

    assert_ack_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_valid, 3));

    assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ack |-> (rsp_rdata == '0));

    assert_err_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ack);

    assert_err_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    assert_enable_moves_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(video_en) |-> rsp_ack);

endmodule

bind dispctl_regbank dispctl_regbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .rsp_ack  (rsp_ack),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .video_en (video_en)
);

// File: tb/dispctl_regbank_tb.sv
`timescale 1ns/1ps
module dispctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_ack, rsp_err;
    logic [31:0] rsp_rdata;
    logic        video_en, pseudo_color;
    logic [1:0]  color_depth;
    logic [31:0] timing_h, timing_v, fb_base_a, fb_base_b;
    logic [15:0] line_len, frame_len;
    logic        disp_bank_sel;
    logic [7:0]  disp_index;
    logic [23:0] disp_color;

    always #2.5 clk = ~clk;

    dispctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .video_en(video_en), .color_depth(color_depth), .pseudo_color(pseudo_color),
        .timing_h(timing_h), .timing_v(timing_v), .line_len(line_len), .frame_len(frame_len),
        .fb_base_a(fb_base_a), .fb_base_b(fb_base_b),
        .disp_bank_sel(disp_bank_sel), .disp_index(disp_index), .disp_color(disp_color)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [32:0] exp_q [$];
    int          when_q[$];
    string       tag_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_ack === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 extra ack: actual 1 expected 0");
            end else begin
                logic [32:0] e;
                int          w;
                string       t;
                e = exp_q.pop_front();
                w = when_q.pop_front();
                t = tag_q.pop_front();
                if ({rsp_err, rsp_rdata} !== e || cyc != w) begin
                    n_bad++;
                    $display("FAIL %s: actual err=%b data=%h cyc=%0d expected err=%b data=%h cyc=%0d",
                             t, rsp_err, rsp_rdata, cyc, e[32], e[31:0], w);
                end
            end
        end
    end

    task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input bit e, input string tag);
        @(negedge clk);
        exp_q.push_back({e, exp});
        when_q.push_back(cyc + 3);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        disp_bank_sel = 1'b0; disp_index = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 exported fields", {video_en, pseudo_color, color_depth, line_len, frame_len},
            32'h0);
        chk("R1 timing/base", timing_h | timing_v | fb_base_a | fb_base_b, 32'h0);
        chk("R1 ack idle", {31'h0, rsp_ack}, 32'h0);
        bus(0, 12'h000, 0, 32'h0, 0, "R1 ctrl read");
        bus(0, 12'h010, 0, 32'hFFFEFFFE, 0, "R1 len read");
        bus(0, 12'h800, 0, 32'h0, 0, "R1 table A");
        bus(0, 12'hFFC, 0, 32'h0, 0, "R1 table B");

        // R2 word registers, R9 no error
        bus(1, 12'h004, 32'hDEADBEEF, 0, 0, "R2 stat write");
        bus(1, 12'h008, 32'h12345678, 0, 0, "R2 htim write");
        bus(1, 12'h00C, 32'h9ABCDEF0, 0, 0, "R2 vtim write");
        bus(1, 12'h014, 32'h80001000, 0, 0, "R2 base A write");
        bus(1, 12'h018, 32'h40002000, 0, 0, "R9 base B write");
        bus(0, 12'h004, 0, 32'hDEADBEEF, 0, "R2 stat read");
        bus(0, 12'h008, 0, 32'h12345678, 0, "R2 htim read");
        bus(0, 12'h00C, 0, 32'h9ABCDEF0, 0, "R2 vtim read");
        bus(0, 12'h014, 0, 32'h80001000, 0, "R2 base A read");
        bus(0, 12'h018, 0, 32'h40002000, 0, "R2 base B read");
        chk("R4 timing_h", timing_h, 32'h12345678);
        chk("R4 timing_v", timing_v, 32'h9ABCDEF0);
        chk("R4 fb_base_a", fb_base_a, 32'h80001000);
        chk("R4 fb_base_b", fb_base_b, 32'h40002000);

        // R4 control fields
        bus(1, 12'h000, 32'hA5000701, 0, 0, "R4 ctrl write");
        chk("R4 fields a", {28'h0, video_en, color_depth, pseudo_color}, 32'hF);
        bus(0, 12'h000, 0, 32'hA5000701, 0, "R2 ctrl read");
        bus(1, 12'h000, 32'h00000200, 0, 0, "R4 ctrl write 2");
        chk("R4 fields b", {28'h0, video_en, color_depth, pseudo_color}, 32'h4);

        // R3 length encoding
        bus(1, 12'h010, 32'h027F01DF, 0, 0, "R3 len write");
        chk("R3 line_len", {16'h0, line_len}, 32'h0281);
        chk("R3 frame_len", {16'h0, frame_len}, 32'h01E1);
        bus(0, 12'h010, 0, 32'h027F01DF, 0, "R3 len read");
        bus(1, 12'h010, 32'hFFFEFFFF, 0, 0, "R3 wrap write");
        chk("R3 wrap lens", {line_len, frame_len}, 32'h00000001);
        bus(0, 12'h010, 0, 32'hFFFEFFFF, 0, "R3 wrap read");

        // R5 colour tables
        bus(1, 12'h800, 32'hAB123456, 0, 0, "R5 A0 write");
        bus(1, 12'hBFC, 32'hFFFFFFFF, 0, 0, "R5 A255 write");
        bus(1, 12'hC00, 32'h00654321, 0, 0, "R5 B0 write");
        bus(1, 12'hFFC, 32'h11ABCDEF, 0, 0, "R5 B255 write");
        bus(0, 12'h800, 0, 32'h00123456, 0, "R5 A0 read masked");
        bus(0, 12'h802, 0, 32'h00123456, 0, "R5 unaligned alias");
        bus(0, 12'hBFC, 0, 32'h00FFFFFF, 0, "R5 A255 read");
        bus(0, 12'hC00, 0, 32'h00654321, 0, "R5 B0 read");
        bus(0, 12'hFFC, 0, 32'h00ABCDEF, 0, "R5 B255 read");

        // R6 display port
        disp_bank_sel = 1'b0; disp_index = 8'd0;   #1 chk("R6 A0", {8'h0, disp_color}, 32'h123456);
        disp_bank_sel = 1'b1; disp_index = 8'd0;   #1 chk("R6 B0", {8'h0, disp_color}, 32'h654321);
        disp_bank_sel = 1'b0; disp_index = 8'd255; #1 chk("R6 A255", {8'h0, disp_color}, 32'hFFFFFF);
        disp_bank_sel = 1'b1; disp_index = 8'd255; #1 chk("R6 B255", {8'h0, disp_color}, 32'hABCDEF);
        disp_bank_sel = 1'b1; disp_index = 8'd7;   #1 chk("R6 B7", {8'h0, disp_color}, 32'h0);

        // R7 unmapped offsets
        bus(0, 12'h01C, 0, 32'h0, 1, "R7 read 0x01C");
        bus(0, 12'h7FC, 0, 32'h0, 1, "R7 read 0x7FC");
        bus(1, 12'h005, 32'hFFFFFFFF, 0, 1, "R7 write 0x005");
        bus(1, 12'h020, 32'hFFFFFFFF, 0, 1, "R7 write 0x020");
        bus(0, 12'h004, 0, 32'hDEADBEEF, 0, "R7 stat unchanged");
        bus(0, 12'h000, 0, 32'h00000200, 0, "R7 ctrl unchanged");
        bus(0, 12'h010, 0, 32'hFFFEFFFF, 0, "R7 len unchanged");
        bus(0, 12'h800, 0, 32'h00123456, 0, "R7 table unchanged");

        // R8 request held while busy: only the first is taken
        @(negedge clk);
        exp_q.push_back({1'b0, 32'h0});
        when_q.push_back(cyc + 3);
        tag_q.push_back("R8 held request");
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h000; req_wdata = 32'h00000001;
        @(negedge clk); req_wdata = 32'h00000400;
        @(negedge clk); req_wdata = 32'h00000300;
        @(negedge clk); req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 queue drained", exp_q.size(), 32'd0);
        bus(0, 12'h000, 0, 32'h00000001, 0, "R8 busy ignored");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule